// File: doc/BRIEF.md
# Pixel Packet Decoder and Panel Selector

This block sits between a UDP receive path and a set of LED panel frame buffers. Each 32-bit payload word updates one pixel. The word carries a row, a column and an 18-bit colour made of three 6-bit channels. The destination port of the datagram says which panels the word is for. The high byte of the port has to match a fixed prefix. The low bits form a mask with one bit per panel, so one word can paint the same pixel on several panels in the same cycle.

The block also watches for live traffic. Out of reset, and whenever no accepted word has arrived for a set number of cycles, it switches the display path to a built-in colour gradient. The gradient is computed from the scan position, so it needs no storage. The next accepted word switches the display back to the frame-buffer data.

Top module: `pxl_word_router`

## Requirements
- R1: After reset, `fb_we` is all zeros and `show_test` is 1.
- R2: For an accepted word, one cycle after it is sampled, `fb_addr` = {row, col} and `fb_rgb` = {red, green, blue}. The fields are taken from the word as row = bits 29:24, col = bits 23:18, red = bits 17:12, green = bits 11:6 and blue = bits 5:0.
- R3: Word bits 31:30 have no effect on any output.
- R4: A word whose port bits 15:8 differ from the prefix (default 0x66) writes no panel and does not reload the silence timer.
- R5: One cycle after an accepted word, `fb_we[i]` equals port bit i for each panel i in 0..5. Several bits may be set at once.
- R6: A word with the right prefix but none of port bits 5:0 set (for example, only bits 7:6 set) writes nothing and is not accepted, so it does not clear `show_test`.
- R7: Each write strobe lasts exactly one cycle per accepted word.
- R8: With no further accepted word, `show_test` rises exactly TIMEOUT_CYC cycles after the clock edge that accepted the last word. It then stays high until another word is accepted.
- R9: The edge that accepts a word clears `show_test`, so it reads 0 from the next cycle on.
- R10: `disp_rgb` is registered. One cycle after the scan inputs are sampled, it holds {scan_x, scan_y, scan_x XOR scan_y} while `show_test` is 1, and `live_rgb` while `show_test` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload word present this cycle |
| in_word | input | 32 | Pixel word |
| in_port | input | 16 | UDP destination port of the word |
| fb_we | output | 6 | One write strobe per panel |
| fb_addr | output | 12 | Pixel address {row, col} |
| fb_rgb | output | 18 | Pixel colour {red, green, blue} |
| show_test | output | 1 | 1 while the test gradient is selected |
| scan_x | input | 6 | Column being scanned out |
| scan_y | input | 6 | Row being scanned out |
| live_rgb | input | 18 | Frame-buffer colour at the scan position |
| disp_rgb | output | 18 | Colour sent to the panel driver |

## Verification
The decoder is driven with words whose fields are all ones, alternating bit patterns, and single-field values. A swapped or shifted field slice therefore shows up as a wrong address or colour. The same word is also sent with bits 31:30 set and cleared, which catches any leakage of those bits into the outputs. Port values cover a single panel, several panels, all panels, the wrong prefix, and a mask with only bits 7:6 set. These separate mask decoding from prefix matching, and both of them from the rule that decides whether the timer reloads. The silence timeout is sampled one cycle before and exactly at the expected edge, so an off-by-one count fails. The display output is compared against an independently computed gradient and against the live input.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    localparam int COORD_W = 6;
    localparam int CHAN_W  = 6;
    localparam int ADDR_W  = 2 * COORD_W;
    localparam int RGB_W   = 3 * CHAN_W;
    localparam int WORD_W  = 32;
    localparam int PORT_W  = 16;

    typedef struct packed {
        logic [COORD_W-1:0] row;
        logic [COORD_W-1:0] col;
        logic [CHAN_W-1:0]  red;
        logic [CHAN_W-1:0]  grn;
        logic [CHAN_W-1:0]  blu;
    } pixel_t;

    function automatic logic [RGB_W-1:0] gradient(input logic [COORD_W-1:0] x,
                                                  input logic [COORD_W-1:0] y);
        return {x, y, x ^ y};
    endfunction
endpackage

// File: rtl/pxl_word_decode.sv
module pxl_word_decode
    import pxl_pkg::*;
#(
    parameter int           NUM_PANELS  = 6,
    parameter logic [7:0]   PORT_PREFIX = 8'h66
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  pixel_t                in_pix,
    input  logic [PORT_W-1:0]     in_port,
    output logic                  accept,
    output logic [NUM_PANELS-1:0] fb_we,
    output logic [ADDR_W-1:0]     fb_addr,
    output logic [RGB_W-1:0]      fb_rgb
);
    typedef struct packed {
        logic [NUM_PANELS-1:0] we;
        logic [ADDR_W-1:0]     addr;
        logic [RGB_W-1:0]      rgb;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       prefix_ok;
    logic [NUM_PANELS-1:0] mask;

    always_comb begin
        prefix_ok = (in_port[PORT_W-1:8] == PORT_PREFIX);
        mask      = in_port[NUM_PANELS-1:0];
        accept    = in_valid && prefix_ok && (mask != '0);
        st_d      = st_q;
        st_d.we   = '0;
        if (accept) begin
            st_d.we   = mask;
            st_d.addr = {in_pix.row, in_pix.col};
            st_d.rgb  = {in_pix.red, in_pix.grn, in_pix.blu};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fb_we   = st_q.we;
    assign fb_addr = st_q.addr;
    assign fb_rgb  = st_q.rgb;

    // R4
    prefix_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_port[PORT_W-1:8] != PORT_PREFIX) |=> (fb_we == '0));
    // R7
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (fb_we == '0));
    // R5
    mask_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (fb_we == $past(in_port[NUM_PANELS-1:0])));
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(fb_addr) && $stable(fb_rgb));
endmodule

// File: rtl/pxl_link_watch.sv
module pxl_link_watch #(
    parameter int TIMEOUT_CYC = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic show_test
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             show;
    } watch_state_t;

    watch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.cnt  = CNT_W'(TIMEOUT_CYC);
            st_d.show = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) st_d.show = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.show <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign show_test = st_q.show;

    // R9
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !show_test);
    // R8
    test_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (show_test && !accept) |=> show_test);
    // R8
    rise_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(show_test) |-> !$past(accept));
endmodule

// File: rtl/pxl_disp_mux.sv
module pxl_disp_mux
    import pxl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               show_test,
    input  logic [COORD_W-1:0] scan_x,
    input  logic [COORD_W-1:0] scan_y,
    input  logic [RGB_W-1:0]   live_rgb,
    output logic [RGB_W-1:0]   disp_rgb
);
    logic [RGB_W-1:0] disp_d, disp_q;

    always_comb begin
        if (show_test) disp_d = gradient(scan_x, scan_y);
        else           disp_d = live_rgb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) disp_q <= '0;
        else        disp_q <= disp_d;
    end

    assign disp_rgb = disp_q;

    // R10
    live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !show_test |=> (disp_rgb == $past(live_rgb)));
endmodule

// File: rtl/pxl_word_router.sv
module pxl_word_router
    import pxl_pkg::*;
#(
    parameter int         NUM_PANELS  = 6,
    parameter logic [7:0] PORT_PREFIX = 8'h66,
    parameter int         TIMEOUT_CYC = 50_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [WORD_W-1:0]     in_word,
    input  logic [PORT_W-1:0]     in_port,
    output logic [NUM_PANELS-1:0] fb_we,
    output logic [ADDR_W-1:0]     fb_addr,
    output logic [RGB_W-1:0]      fb_rgb,
    output logic                  show_test,
    input  logic [COORD_W-1:0]    scan_x,
    input  logic [COORD_W-1:0]    scan_y,
    input  logic [RGB_W-1:0]      live_rgb,
    output logic [RGB_W-1:0]      disp_rgb
);
    logic   accept;
    pixel_t pix;
    logic   unused_bits;

    assign pix         = pixel_t'(in_word[$bits(pixel_t)-1:0]);
    assign unused_bits = ^{in_word[WORD_W-1:$bits(pixel_t)], in_port[7:0]};

    pxl_word_decode #(
        .NUM_PANELS (NUM_PANELS),
        .PORT_PREFIX(PORT_PREFIX)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_pix  (pix),
        .in_port (in_port),
        .accept  (accept),
        .fb_we   (fb_we),
        .fb_addr (fb_addr),
        .fb_rgb  (fb_rgb)
    );

    pxl_link_watch #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .show_test(show_test)
    );

    pxl_disp_mux u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .show_test(show_test),
        .scan_x   (scan_x),
        .scan_y   (scan_y),
        .live_rgb (live_rgb),
        .disp_rgb (disp_rgb)
    );
endmodule

// File: tb/tb_pxl_word_router.sv
`timescale 1ns/1ps
module tb_pxl_word_router;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [15:0] in_port = '0;
    logic [5:0]  fb_we;
    logic [11:0] fb_addr;
    logic [17:0] fb_rgb;
    logic        show_test;
    logic [5:0]  scan_x = '0, scan_y = '0;
    logic [17:0] live_rgb = '0;
    logic [17:0] disp_rgb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pxl_word_router #(.TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_port(in_port), .fb_we(fb_we), .fb_addr(fb_addr), .fb_rgb(fb_rgb),
        .show_test(show_test), .scan_x(scan_x), .scan_y(scan_y),
        .live_rgb(live_rgb), .disp_rgb(disp_rgb)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] hi, input logic [5:0] y,
        input logic [5:0] x, input logic [5:0] r, input logic [5:0] g, input logic [5:0] b);
        return {hi, y, x, r, g, b};
    endfunction

    // Drive one word before an edge, return at the following negedge with valid low.
    task automatic send(input logic [31:0] w, input logic [15:0] p);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_port = p;
        @(negedge clk);
        in_valid = 1'b0; in_word = '0; in_port = '0;
    endtask

    task automatic t_reset();
        chk(fb_we == 6'h0, "R1 fb_we after reset", fb_we, 0);
        chk(show_test == 1'b1, "R1 show_test after reset", show_test, 1);
    endtask

    task automatic t_gradient();
        scan_x = 6'h2A; scan_y = 6'h13; live_rgb = 18'h3FFFF;
        @(negedge clk);
        chk(disp_rgb == {6'h2A, 6'h13, 6'h2A ^ 6'h13}, "R10 gradient a", disp_rgb,
            {6'h2A, 6'h13, 6'h39});
        scan_x = 6'h3F; scan_y = 6'h00;
        @(negedge clk);
        chk(disp_rgb == {6'h3F, 6'h00, 6'h3F}, "R10 gradient b", disp_rgb, {6'h3F, 6'h00, 6'h3F});
    endtask

    task automatic t_bad_prefix();
        send(mk(2'b00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05), 16'h673F);
        chk(fb_we == 6'h0, "R4 wrong prefix no write", fb_we, 0);
        @(negedge clk);
        chk(show_test == 1'b1, "R4 wrong prefix keeps test screen", show_test, 1);
    endtask

    task automatic t_empty_mask();
        send(mk(2'b00, 6'h07, 6'h08, 6'h09, 6'h0A, 6'h0B), 16'h66C0);
        chk(fb_we == 6'h0, "R6 upper-bit-only mask no write", fb_we, 0);
        @(negedge clk);
        chk(show_test == 1'b1, "R6 empty mask not accepted", show_test, 1);
        send(mk(2'b00, 6'h07, 6'h08, 6'h09, 6'h0A, 6'h0B), 16'h6600);
        chk(fb_we == 6'h0, "R6 zero mask no write", fb_we, 0);
    endtask

    task automatic t_decode();
        logic [5:0] ys [3] = '{6'h3F, 6'h2A, 6'h01};
        logic [5:0] xs [3] = '{6'h3F, 6'h15, 6'h20};
        logic [5:0] rs [3] = '{6'h3F, 6'h2A, 6'h00};
        logic [5:0] gs [3] = '{6'h3F, 6'h15, 6'h10};
        logic [5:0] bs [3] = '{6'h3F, 6'h2A, 6'h00};
        for (int i = 0; i < 3; i++) begin
            send(mk(2'b00, ys[i], xs[i], rs[i], gs[i], bs[i]), 16'h6601);
            chk(fb_addr == {ys[i], xs[i]}, "R2 address", fb_addr, {ys[i], xs[i]});
            chk(fb_rgb == {rs[i], gs[i], bs[i]}, "R2 colour", fb_rgb, {rs[i], gs[i], bs[i]});
            chk(show_test == 1'b0, "R9 accept clears test screen", show_test, 0);
            @(negedge clk);
            chk(fb_we == 6'h0, "R7 strobe lasts one cycle", fb_we, 0);
        end
        send(mk(2'b11, 6'h05, 6'h06, 6'h07, 6'h08, 6'h09), 16'h6602);
        chk(fb_addr == {6'h05, 6'h06}, "R3 high bits ignored addr", fb_addr, {6'h05, 6'h06});
        chk(fb_rgb == {6'h07, 6'h08, 6'h09}, "R3 high bits ignored rgb", fb_rgb,
            {6'h07, 6'h08, 6'h09});
        chk(fb_we == 6'h02, "R3 high bits ignored we", fb_we, 6'h02);
    endtask

    task automatic t_live();
        live_rgb = 18'h2B3C4; scan_x = 6'h11; scan_y = 6'h22;
        @(negedge clk);
        chk(show_test == 1'b0, "R10 precondition live", show_test, 0);
        chk(disp_rgb == 18'h2B3C4, "R10 live pass-through", disp_rgb, 18'h2B3C4);
    endtask

    task automatic t_masks();
        logic [5:0] ms [4] = '{6'h01, 6'h20, 6'h15, 6'h3F};
        for (int i = 0; i < 4; i++) begin
            send(mk(2'b00, 6'h0C, 6'h0D, 6'h01, 6'h02, 6'h03), {8'h66, 2'b00, ms[i]});
            chk(fb_we == ms[i], "R5 panel mask", fb_we, ms[i]);
        end
        send(mk(2'b00, 6'h0C, 6'h0D, 6'h01, 6'h02, 6'h03), 16'h66C4);
        chk(fb_we == 6'h04, "R5 upper bits dropped from mask", fb_we, 6'h04);
    endtask

    task automatic t_timeout();
        send(mk(2'b00, 6'h01, 6'h01, 6'h01, 6'h01, 6'h01), 16'h6610);
        repeat (TMO - 1) @(negedge clk);
        chk(show_test == 1'b0, "R8 not yet timed out", show_test, 0);
        @(negedge clk);
        chk(show_test == 1'b1, "R8 timed out on time", show_test, 1);
        repeat (5) @(negedge clk);
        chk(show_test == 1'b1, "R8 stays in test screen", show_test, 1);
        send(mk(2'b00, 6'h01, 6'h01, 6'h01, 6'h01, 6'h01), 16'h6608);
        chk(show_test == 1'b0, "R9 word leaves test screen", show_test, 0);
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL R8 watchdog expired act=%0h exp=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gradient();
        t_bad_prefix();
        t_empty_mask();
        t_decode();
        t_live();
        t_masks();
        t_timeout();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule